// File: doc/BRIEF.md
# Segmented Carry-Select Byte Adder

This block adds two 8-bit operands and a carry input. It produces an 8-bit sum and a carry output. Every bit first forms three local terms: the operand difference (a xor b), a propagate term (a or b) and a generate term (a and b).

The bits are split into four uneven segments, starting at the least significant bit: two bits, then three, then two, then one. Each segment works out its internal carries twice, once for an incoming carry of 0 and once for 1. The real carry moves from segment to segment only through one selection multiplexer per segment, which picks between the two precomputed sets. The sum bits are formed last, from the operand difference and the selected carry into each bit.

Operands and carry input are captured on a rising clock edge. The sum and the carry output are registered on the next rising edge. An active-low synchronous reset clears every register. The block has no control states: it is a two-stage pipeline that accepts a new operand set on every cycle.

Top module: `seg_csel_adder8`

## Requirements
- R1: Operands presented before rising edge k appear on `sum_out` and `c_out` after rising edge k+1, and a new operand set is accepted on every cycle.
- R2: While `rst_n` is low at a rising edge, the input and output registers are cleared, so `sum_out` reads 0 and `c_out` reads 0 after that edge, whatever the operand pins carry.
- R3: `sum_out` equals the low 8 bits of `a_in + b_in + c_in` for the operands captured one edge earlier.
- R4: `c_out` equals bit 8 of `a_in + b_in + c_in`, the ninth bit of the full sum.
- R5: The segments cover bits {1:0}, {4:2}, {6:5} and {7}. When every bit of a segment has a xor b = 1, the segment passes its incoming carry unchanged to the next segment. This holds for both carry-in values and for any combination of fully propagating segments.
- R6: With a = 8'b10110111, b = 8'b01001001 and carry input 1, the carry generated at bit 0 crosses all four segment multiplexers. The result is sum 8'h01 and carry output 1.
- R7: Operands of all zeros give sum 8'h00 with carry input 0, and 8'h01 with carry input 1, with carry output 0 in both cases. Operands of all ones give sum 8'hFE or 8'hFF, with carry output 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 8 | First operand |
| b_in | input | 8 | Second operand |
| c_in | input | 1 | Carry input |
| sum_out | output | 8 | Registered sum |
| c_out | output | 1 | Registered carry output |

## Verification
The bench builds the block with its default segment split of 2/3/2/1 bits over an 8-bit word. With that split, a 4-bit mask can enumerate every combination of fully propagating segments, and each combination is run with both carry-in values, so every path through the multiplexer chain is used. The reference model is a plain integer addition delayed through a two-entry queue, so it is independent of the segment boundaries. It is compared on every cycle across the fixed corner vectors, the segment patterns and ten thousand random operand sets.

// File: rtl/csa_pkg.sv
package csa_pkg;
    localparam int ADD_W = 8;
    localparam int NSEG  = 4;

    // Width of segment s, least significant segment first.
    function automatic int seg_width(input int s);
        case (s)
            0:       return 2;
            1:       return 3;
            2:       return 2;
            default: return 1;
        endcase
    endfunction

    // Index of the lowest bit of segment s.
    function automatic int seg_lo(input int s);
        int acc;
        acc = 0;
        for (int k = 0; k < s; k++) acc += seg_width(k);
        return acc;
    endfunction
endpackage

// File: rtl/csa_bitprep.sv
module csa_bitprep #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] x,
    output logic [W-1:0] p,
    output logic [W-1:0] g
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign x[i] = a[i] ^ b[i];
        assign p[i] = a[i] | b[i];
        assign g[i] = a[i] & b[i];
    end
endmodule

// File: rtl/csa_segment.sv
module csa_segment #(
    parameter int W = 2
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] p,
    input  logic [W-1:0] g,
    output logic [W:0]   cz,   // carries assuming incoming carry 0
    output logic [W:0]   co    // carries assuming incoming carry 1
);
    assign cz[0] = 1'b0;
    assign co[0] = 1'b1;
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign cz[i+1] = g[i] | (p[i] & cz[i]);
        assign co[i+1] = g[i] | (p[i] & co[i]);
    end

    // R5: a fully propagating segment hands its carry-in straight through
    always_comb begin
        if (&x) begin
            a_r5_pass_through: assert (cz[W] == 1'b0 && co[W] == 1'b1);
        end
        // R5: carry-in 1 can never yield a smaller carry-out than carry-in 0
        a_r5_dual_order: assert (!(cz[W] && !co[W]));
    end
endmodule

// File: rtl/csa_carry_mux.sv
module csa_carry_mux #(
    parameter int W = 2
) (
    input  logic       sel,
    input  logic [W:0] cz,
    input  logic [W:0] co,
    output logic [W:0] c
);
    assign c = sel ? co : cz;
endmodule

// File: rtl/seg_csel_adder8.sv
module seg_csel_adder8
    import csa_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADD_W-1:0] a_in,
    input  logic [ADD_W-1:0] b_in,
    input  logic             c_in,
    output logic [ADD_W-1:0] sum_out,
    output logic             c_out
);
    logic [ADD_W-1:0] a_q, b_q;
    logic             c_q;
    logic [ADD_W-1:0] x_w, p_w, g_w;
    logic [ADD_W-1:0] cbit;
    logic [NSEG:0]    seg_c;

    // Input capture stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= 1'b0;
        end else begin
            a_q <= a_in;
            b_q <= b_in;
            c_q <= c_in;
        end
    end

    csa_bitprep #(.W(ADD_W)) u_prep (
        .a(a_q), .b(b_q), .x(x_w), .p(p_w), .g(g_w)
    );

    assign seg_c[0] = c_q;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        localparam int LO = seg_lo(s);
        localparam int SW = seg_width(s);
        logic [SW:0] cz, co, csel;

        csa_segment #(.W(SW)) u_seg (
            .x(x_w[LO +: SW]), .p(p_w[LO +: SW]), .g(g_w[LO +: SW]),
            .cz(cz), .co(co)
        );

        csa_carry_mux #(.W(SW)) u_mux (
            .sel(seg_c[s]), .cz(cz), .co(co), .c(csel)
        );

        assign cbit[LO +: SW] = csel[SW-1:0];
        assign seg_c[s+1]     = csel[SW];
    end

    // Output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_out <= '0;
            c_out   <= 1'b0;
        end else begin
            sum_out <= x_w ^ cbit;
            c_out   <= seg_c[NSEG];
        end
    end

    // R2: reset clears the visible result
    a_r2_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (sum_out == '0 && c_out == 1'b0));

    // R3: sum matches arithmetic addition of the captured operands
    a_r3_sum_matches: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> sum_out == $past(a_q + b_q + {{(ADD_W-1){1'b0}}, c_q}));

    // R4: carry output is the ninth bit of the full sum
    a_r4_cout_matches: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> c_out == $past(({1'b0, a_q} + {1'b0, b_q}
                                   + {{ADD_W{1'b0}}, c_q}) >> ADD_W));
endmodule

// File: tb/test_seg_csel_adder8.sv
`timescale 1ns/1ps
module test_seg_csel_adder8;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = 8'h00, b_in = 8'h00;
    logic       c_in = 1'b0;
    logic [7:0] sum_out;
    logic       c_out;

    int checks = 0;
    int errors = 0;
    logic [8:0] pend[$];
    string      cur_tag = "R3";

    always #2.5 clk = ~clk;

    seg_csel_adder8 i_seg_csel_adder8 (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .sum_out(sum_out), .c_out(c_out)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: compare result of operands from two cycles ago (R1), then drive new operands.
    task automatic step(input logic [7:0] a, input logic [7:0] b, input logic c);
        logic [8:0] e;
        @(negedge clk);
        if (pend.size() == 2) begin
            e = pend.pop_front();
            check({"R1/R3 ", cur_tag}, {1'b0, sum_out}, {1'b0, e[7:0]});
            check({"R1/R4 ", cur_tag}, {8'b0, c_out}, {8'b0, e[8]});
        end
        a_in = a; b_in = b; c_in = c;
        pend.push_back({1'b0, a} + {1'b0, b} + {8'b0, c});
    endtask

    task automatic flush();
        step(8'h00, 8'h00, 1'b0);
        step(8'h00, 8'h00, 1'b0);
    endtask

    localparam logic [7:0] SEGMASK [4] = '{8'h03, 8'h1C, 8'h60, 8'h80};

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 reset sum", {1'b0, sum_out}, 9'h000);
        check("R2 reset cout", {8'b0, c_out}, 9'h000);
        rst_n = 1'b1;
        pend.push_back(9'h000);
        pend.push_back(9'h000);

        cur_tag = "R7 zeros";
        step(8'h00, 8'h00, 1'b0);
        step(8'h00, 8'h00, 1'b1);
        cur_tag = "R7 ones";
        step(8'hFF, 8'hFF, 1'b0);
        step(8'hFF, 8'hFF, 1'b1);
        cur_tag = "R6 worst";
        step(8'b10110111, 8'b01001001, 1'b1);
        flush();

        // R5: every combination of fully propagating segments, both carry-ins
        cur_tag = "R5 segments";
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < 2; c++) begin
                logic [7:0] mk;
                mk = 8'h00;
                for (int s = 0; s < 4; s++) if (m[s]) mk |= SEGMASK[s];
                step(mk & 8'h55, mk & 8'hAA, c[0]);
                step((mk & 8'h55) | (~mk & 8'($urandom)),
                     (mk & 8'hAA) | (~mk & 8'($urandom)), c[0]);
            end
        end
        flush();

        // R2: reset mid-stream with busy inputs
        @(negedge clk);
        rst_n = 1'b0; a_in = 8'hFF; b_in = 8'hFF; c_in = 1'b1;
        @(negedge clk);
        check("R2 mid reset sum", {1'b0, sum_out}, 9'h000);
        check("R2 mid reset cout", {8'b0, c_out}, 9'h000);
        pend.delete();
        a_in = 8'h00; b_in = 8'h00; c_in = 1'b0;
        rst_n = 1'b1;
        pend.push_back(9'h000);
        pend.push_back(9'h000);

        cur_tag = "R3 random";
        for (int n = 0; n < 10000; n++)
            step(8'($urandom), 8'($urandom), 1'($urandom));
        flush();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule